// File: doc/BRIEF.md
# Serial-Loaded Latched Switch Control Register

This block is the digital control front end for a bank of high-voltage switch channels. A bit stream arrives one bit per enabled clock and moves through a chain of shift stages. A separate hold register, governed by an active-low load control, decides which pattern reaches the switch-enable outputs. The block needs no clock toggling while the outputs are frozen, so a new pattern can be staged without disturbing the switches.

The serial clock is treated as a clock enable (`shift_en_i`) on the system clock. While `load_ni` is low, the outputs follow the shift chain in the same cycle. When `load_ni` goes high, the hold register freezes the last pattern that was shown. A high `clear_i` forces every output off at once. It does not touch the stored patterns, so the outputs come back when clear is released. The last shift stage is driven out on `dout_o` so that several blocks can be chained in series.

Top module: `swctl_top`

## Requirements
- R1: After reset, every stage of the shift chain and of the hold register is 0, so `sw_en_o` is all zeros and `dout_o` is 0.
- R2: On a rising clock edge with `shift_en_i` high, stage 0 takes `sdata_i` and stage n takes the old stage n-1. With `shift_en_i` low, the chain keeps its contents.
- R3: The first of 16 shifted bits sits in stage 15 after the 16th shift. Stage n drives `sw_en_o[n]`, where 1 means switch on and 0 means switch off.
- R4: While `load_ni` is low and `clear_i` is low, `sw_en_o` equals the current shift chain contents in the same cycle.
- R5: When `load_ni` goes high, the hold register keeps the pattern that `sw_en_o` showed just before the rise.
- R6: While `load_ni` stays high, shifting does not change `sw_en_o`.
- R7: While `clear_i` is high, `sw_en_o` is all zeros without waiting for a clock edge, whatever the other inputs are. The chain and the hold register keep their contents, so the earlier outputs return when `clear_i` falls.
- R8: `dout_o` is high exactly when stage 15 of the chain is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| sdata_i | input | 1 | Serial data bit |
| shift_en_i | input | 1 | Shift strobe; the chain advances on the clock edge when high |
| load_ni | input | 1 | Active-low load; low = outputs follow the chain, high = hold |
| clear_i | input | 1 | Forces all switch enables off |
| sw_en_o | output | 16 | Switch-enable outputs, 1 = on |
| dout_o | output | 1 | Cascade output, the value of the last shift stage |

## Verification
Random streams mix shift strobes, load toggles and clear pulses with uneven densities. A model in the bench is compared against the outputs on every cycle, which separates correct pass-through from a latch that is one cycle late. A directed load of a known 16-bit word with the hold closed checks two things: that the first bit lands on channel 15, and that shifting with the hold closed leaves the outputs untouched. A clear pulse in the middle of a pattern, followed by its release, shows whether clear wipes the stored state or only masks the outputs.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
  parameter int unsigned CHANNELS = 16;
  typedef logic [CHANNELS-1:0] chan_vec_t;
endpackage

// File: rtl/swctl_rst_sync.sv
module swctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/swctl_shift_chain.sv
module swctl_shift_chain #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdata_i,
  input  logic             shift_en_i,
  output logic [WIDTH-1:0] chain_q_o,
  output logic [WIDTH-1:0] chain_d_o
);
  localparam int unsigned LAST = WIDTH - 1;
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] chain_d;

  always_comb begin
    chain_d = chain_q;
    if (shift_en_i) chain_d = {chain_q[LAST-1:0], sdata_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign chain_q_o = chain_q;
  assign chain_d_o = chain_d;

  // R2
  shift_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> (chain_q[0] == $past(sdata_i)) && (chain_q[LAST:1] == $past(chain_q[LAST-1:0])));
  // R2
  shift_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(chain_q));
endmodule

// File: rtl/swctl_hold_reg.sv
module swctl_hold_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] next_i,
  output logic [WIDTH-1:0] hold_q_o
);
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] hold_d;
  logic             hold_en;

  always_comb begin
    hold_en = !load_ni;
    hold_d  = hold_en ? next_i : hold_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else         hold_q <= hold_d;
  end

  assign hold_q_o = hold_q;

  // R6
  hold_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ni |=> $stable(hold_q));
endmodule

// File: rtl/swctl_top.sv
module swctl_top #(
  parameter int unsigned WIDTH       = swctl_pkg::CHANNELS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdata_i,
  input  logic             shift_en_i,
  input  logic             load_ni,
  input  logic             clear_i,
  output logic [WIDTH-1:0] sw_en_o,
  output logic             dout_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic             rst_sn;
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] chain_d;
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] pick;

  swctl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_sn)
  );

  swctl_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk_i(clk_i), .rst_ni(rst_sn), .sdata_i(sdata_i), .shift_en_i(shift_en_i),
    .chain_q_o(chain_q), .chain_d_o(chain_d)
  );

  swctl_hold_reg #(.WIDTH(WIDTH)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_sn), .load_ni(load_ni),
    .next_i(chain_d), .hold_q_o(hold_q)
  );

  always_comb begin
    pick    = load_ni ? hold_q : chain_q;
    sw_en_o = clear_i ? '0 : pick;
  end

  assign dout_o = chain_q[LAST];

  // R7
  clear_off_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    clear_i |-> (sw_en_o == '0));
  // R5
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    !load_ni |=> (hold_q == chain_q));
  // R6
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (load_ni && !clear_i && $past(load_ni) && !$past(clear_i)) |-> $stable(sw_en_o));
  // R8
  cascade_chk: assert property (@(posedge clk_i) disable iff (!rst_sn)
    shift_en_i |=> (dout_o == $past(chain_q[LAST-1])));
endmodule

// File: tb/swctl_top_tb_top.sv
module swctl_top_tb_top;
  localparam int W = 16;
  logic clk = 0, rst_n = 0, sdata = 0, shen = 0, ld_n = 1, clr = 0;
  logic [W-1:0] sw;
  logic dout;
  int checks = 0, fails = 0;
  logic [W-1:0] m_sh = '0, m_hd = '0;

  always #10 clk = ~clk;

  swctl_top dut_i (.clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .shift_en_i(shen),
    .load_ni(ld_n), .clear_i(clr), .sw_en_o(sw), .dout_o(dout));

  function automatic logic [W-1:0] exp_out(logic [W-1:0] sh, logic [W-1:0] hd, logic l, logic c);
    if (c) return '0;
    return l ? hd : sh;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic d, logic se, logic l, logic c, string tag);
    @(negedge clk);
    sdata = d; shen = se; ld_n = l; clr = c;
    #1;
    chk(tag, sw, exp_out(m_sh, m_hd, l, c));
    chk("R8 dout", {15'd0, dout}, {15'd0, m_sh[W-1]});
    @(posedge clk);
    if (se) m_sh = {m_sh[W-2:0], d};
    if (!l) m_hd = m_sh;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] word;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 sw_en", sw, '0);
    chk("R1 dout", {15'd0, dout}, '0);
    // R3 / R6: load word with hold closed, first bit = word[15]
    word = 16'hA5C3;
    for (int i = W - 1; i >= 0; i--) step(word[i], 1'b1, 1'b1, 1'b0, "R6 hold while shifting");
    chk("R6 outputs unchanged", sw, '0);
    step(1'b0, 1'b0, 1'b0, 1'b0, "R4 pass-through");
    chk("R3 word placement", sw, word);
    // R5 capture, then shift with hold closed
    step(1'b1, 1'b1, 1'b0, 1'b0, "R4 pass-through shifting");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R5 captured pattern");
    chk("R5 hold value", sw, {word[W-2:0], 1'b1});
    // R7 clear masks, state survives
    step(1'b0, 1'b1, 1'b1, 1'b1, "R7 clear forces off");
    step(1'b0, 1'b0, 1'b0, 1'b1, "R7 clear overrides pass-through");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R7 pattern returns after clear");
    chk("R7 chain kept", sw, m_sh);
    // R2 random mix
    for (int n = 0; n < 3000; n++) begin
      step(1'($urandom), ($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 11) == 0,
           "R2 random model compare");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule